// File: doc/BRIEF.md
# CCD Line Clamp Pulse Generator

This block produces the clamp timing that a CCD analog front end needs on every line. A pixel counter, clocked by the pixel clock, moves across the line. Three clamp pulses are decoded from its position: an optical-black clamp at the start of the line, a dummy-pixel clamp at the end of the line, and a converter-input clamp. The converter-input clamp always covers the same pixels as the dummy-pixel clamp. Every pixel that lies in neither clamp window is flagged as active video.

A line-start strobe sends the counter back to pixel zero on the next clock. With no strobe the counter runs freely and wraps at the configured line length. A static polarity input selects active-high or active-low clamp outputs. The video flag is always active high. For sensors that have no dummy pixels, a build parameter moves the dummy and converter clamp windows into a flyback span at a position set by parameters.

The line length, the two window lengths and the flyback span are parameters. The defaults are 1024 pixels per line and 40-pixel clamp windows. Each window must be at least one pixel long and shorter than half a line. The flyback span must lie clear of the optical-black window and inside the line.

Top module: `ccd_clamp_gen`

## Requirements
- R1: After synchronous reset the counter is at pixel 0, so with active-high polarity the optical-black clamp is 1, the dummy and converter clamps are 0, and the video flag is 0.
- R2: With no line-start strobe the pixel position rises by one each clock and goes from LINE_LEN-1 back to 0, so the output pattern repeats every LINE_LEN clocks.
- R3: A line-start strobe high at a rising edge puts the pixel position at 0 after that edge, whatever the position was. This holds for repeated strobes as well.
- R4: The optical-black clamp is active exactly for pixel positions 0 to OB_LEN-1.
- R5: With dummy pixels present (HAS_DUMMY=1), the dummy clamp is active exactly for positions LINE_LEN-DM_LEN to LINE_LEN-1.
- R6: The converter-input clamp is active on exactly the same pixels as the dummy clamp.
- R7: With no dummy pixels (HAS_DUMMY=0), the dummy and converter clamps are active exactly for positions FLY_START to FLY_START+FLY_LEN-1. Nothing is active at the line end.
- R8: When clamp_active_low is 1, all three clamp outputs are the inverse of their active-high values in the same cycle. When it is 0 they are active high. The video flag does not depend on this input.
- R9: video_active is 1 exactly on the pixels where neither the optical-black clamp nor the dummy/converter clamp is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| line_start | input | 1 | Line-start strobe; pixel position goes to 0 on the next edge |
| clamp_active_low | input | 1 | 1: clamp outputs active low; 0: active high |
| clamp_ob | output | 1 | Optical-black clamp pulse |
| clamp_dm | output | 1 | Dummy-pixel clamp pulse |
| clamp_adc | output | 1 | Converter-input clamp pulse |
| video_active | output | 1 | High on active video pixels |

## Verification
All outputs are decoded without delay from the counter state. A wrong pixel position therefore shows on the ports in the same cycle it occurs: a window edge appears one or more pixels early or late, or the line period changes. A counter that misses a wrap or a restart shifts every later window edge, so the error is visible within one line of the fault. A mismatch between the converter and dummy windows, or a pixel that is both clamped and flagged as video, shows up at the first pixel where the two decodes disagree.

// File: rtl/ccd_clamp_pkg.sv
package ccd_clamp_pkg;

    typedef struct packed {
        logic ob;
        logic dm;
        logic adc;
    } clamp_set_t;

    // Half-open span test: first <= pos < first + len
    function automatic logic in_span(input int unsigned pos,
                                     input int unsigned first,
                                     input int unsigned len);
        return (pos >= first) && (pos < first + len);
    endfunction

    // Closed range test used by an independent decode path
    function automatic logic in_range(input int unsigned pos,
                                      input int unsigned lo,
                                      input int unsigned hi);
        return (pos >= lo) && (pos <= hi);
    endfunction

endpackage

// File: rtl/ccd_pix_counter.sv
module ccd_pix_counter #(
    parameter int unsigned LINE_LEN = 1024,
    parameter int unsigned CW       = $clog2(LINE_LEN)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          line_start,
    output logic [CW-1:0] pix
);
    localparam logic [CW-1:0] LAST = CW'(LINE_LEN - 1);

    always_ff @(posedge clk) begin
        if (rst || line_start) begin
            pix <= '0;
        end else if (pix == LAST) begin
            pix <= '0;
        end else begin
            pix <= pix + 1'b1;
        end
    end

    assert_wrap_R2: assert property (@(posedge clk) disable iff (rst)
        (pix == LAST && !line_start) |=> (pix == '0));

    assert_step_R2: assert property (@(posedge clk) disable iff (rst)
        (pix != LAST && !line_start) |=> (pix == $past(pix) + 1'b1));

    assert_restart_R3: assert property (@(posedge clk) disable iff (rst)
        line_start |=> (pix == '0));

    assert_in_line_R2: assert property (@(posedge clk) disable iff (rst)
        32'(pix) < LINE_LEN);

endmodule

// File: rtl/ccd_window_decode.sv
module ccd_window_decode
    import ccd_clamp_pkg::*;
#(
    parameter int unsigned LINE_LEN  = 1024,
    parameter int unsigned OB_LEN    = 40,
    parameter int unsigned DM_LEN    = 40,
    parameter bit          HAS_DUMMY = 1'b1,
    parameter int unsigned FLY_START = 48,
    parameter int unsigned FLY_LEN   = 16,
    parameter int unsigned CW        = $clog2(LINE_LEN)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] pix,
    output clamp_set_t    raw,
    output logic          video
);
    localparam int unsigned DM_FIRST = LINE_LEN - DM_LEN;
    localparam int unsigned FLY_LAST = FLY_START + FLY_LEN - 1;

    int unsigned p;
    assign p = 32'(pix);

    always_comb raw.ob = in_span(p, 0, OB_LEN);

    generate
        if (HAS_DUMMY) begin : g_dummy
            always_comb begin
                raw.dm  = in_span(p, DM_FIRST, DM_LEN);
                raw.adc = in_range(p, DM_FIRST, LINE_LEN - 1);
                video   = in_range(p, OB_LEN, DM_FIRST - 1);
            end

            assert_line_end_R5: assert property (@(posedge clk) disable iff (rst)
                (p == LINE_LEN - 1) |-> raw.dm);
        end else begin : g_flyback
            always_comb begin
                raw.dm  = in_span(p, FLY_START, FLY_LEN);
                raw.adc = in_range(p, FLY_START, FLY_LAST);
                video   = in_range(p, OB_LEN, FLY_START - 1)
                        | in_range(p, FLY_LAST + 1, LINE_LEN - 1);
            end

            assert_no_end_clamp_R7: assert property (@(posedge clk) disable iff (rst)
                (p == LINE_LEN - 1) |-> !raw.dm);
        end
    endgenerate

    assert_adc_match_R6: assert property (@(posedge clk) disable iff (rst)
        raw.adc == raw.dm);

    assert_video_excl_R9: assert property (@(posedge clk) disable iff (rst)
        video |-> !(raw.ob || raw.dm));

    assert_video_cover_R9: assert property (@(posedge clk) disable iff (rst)
        !video |-> (raw.ob || raw.dm));

    assert_ob_first_R4: assert property (@(posedge clk) disable iff (rst)
        (p == 0) |-> raw.ob);

endmodule

// File: rtl/ccd_clamp_polarity.sv
module ccd_clamp_polarity
    import ccd_clamp_pkg::*;
(
    input  clamp_set_t raw,
    input  logic       active_low,
    output logic       ob_o,
    output logic       dm_o,
    output logic       adc_o
);
    clamp_set_t drv;

    always_comb begin
        drv   = raw ^ {3{active_low}};
        ob_o  = drv.ob;
        dm_o  = drv.dm;
        adc_o = drv.adc;
    end

endmodule

// File: rtl/ccd_clamp_gen.sv
module ccd_clamp_gen
    import ccd_clamp_pkg::*;
#(
    parameter int unsigned LINE_LEN  = 1024,
    parameter int unsigned OB_LEN    = 40,
    parameter int unsigned DM_LEN    = 40,
    parameter bit          HAS_DUMMY = 1'b1,
    parameter int unsigned FLY_START = 48,
    parameter int unsigned FLY_LEN   = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic line_start,
    input  logic clamp_active_low,
    output logic clamp_ob,
    output logic clamp_dm,
    output logic clamp_adc,
    output logic video_active
);
    localparam int unsigned CW = $clog2(LINE_LEN);

    logic [CW-1:0] pix;
    clamp_set_t    raw;

    ccd_pix_counter #(.LINE_LEN(LINE_LEN), .CW(CW)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .line_start (line_start),
        .pix        (pix)
    );

    ccd_window_decode #(
        .LINE_LEN  (LINE_LEN),
        .OB_LEN    (OB_LEN),
        .DM_LEN    (DM_LEN),
        .HAS_DUMMY (HAS_DUMMY),
        .FLY_START (FLY_START),
        .FLY_LEN   (FLY_LEN),
        .CW        (CW)
    ) u_dec (
        .clk   (clk),
        .rst   (rst),
        .pix   (pix),
        .raw   (raw),
        .video (video_active)
    );

    ccd_clamp_polarity u_pol (
        .raw        (raw),
        .active_low (clamp_active_low),
        .ob_o       (clamp_ob),
        .dm_o       (clamp_dm),
        .adc_o      (clamp_adc)
    );

    assert_pol_split_R8: assert property (@(posedge clk) disable iff (rst)
        (clamp_ob ^ clamp_active_low) |-> !video_active);

endmodule

// File: tb/test_ccd_clamp_gen.sv
module test_ccd_clamp_gen;

    localparam int LA = 1024, OA = 40, DA = 40;
    localparam int LB = 128, OB = 10, FSB = 20, FLB = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic line_start = 1'b0;
    logic clamp_active_low = 1'b0;

    logic a_ob, a_dm, a_adc, a_vid;
    logic b_ob, b_dm, b_adc, b_vid;

    int checks = 0;
    int failures = 0;
    int pos_a = 0;
    int pos_b = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    ccd_clamp_gen i_ccd_clamp_gen (
        .clk(clk), .rst(rst), .line_start(line_start),
        .clamp_active_low(clamp_active_low),
        .clamp_ob(a_ob), .clamp_dm(a_dm), .clamp_adc(a_adc), .video_active(a_vid)
    );

    ccd_clamp_gen #(
        .LINE_LEN(LB), .OB_LEN(OB), .DM_LEN(8), .HAS_DUMMY(1'b0),
        .FLY_START(FSB), .FLY_LEN(FLB)
    ) i_ccd_clamp_gen_fly (
        .clk(clk), .rst(rst), .line_start(line_start),
        .clamp_active_low(clamp_active_low),
        .clamp_ob(b_ob), .clamp_dm(b_dm), .clamp_adc(b_adc), .video_active(b_vid)
    );

    task automatic chk(input logic act, input logic exp, input string req, input string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s [%s] actual=%b expected=%b pos_a=%0d pos_b=%0d",
                     req, tag, act, exp, pos_a, pos_b);
        end
    endtask

    task automatic compare(input string tag);
        logic e_ob, e_dm, e_vid, pol;
        pol = clamp_active_low;
        e_ob  = (pos_a < OA);
        e_dm  = (pos_a >= LA - DA);
        e_vid = !e_ob && !e_dm;
        chk(a_ob,  e_ob ^ pol, "R4", tag);
        chk(a_dm,  e_dm ^ pol, "R5", tag);
        chk(a_adc, e_dm ^ pol, "R6", tag);
        chk(a_vid, e_vid,      "R9", tag);
        e_ob  = (pos_b < OB);
        e_dm  = (pos_b >= FSB) && (pos_b < FSB + FLB);
        e_vid = !e_ob && !e_dm;
        chk(b_ob,  e_ob ^ pol, "R4", tag);
        chk(b_dm,  e_dm ^ pol, "R7", tag);
        chk(b_adc, e_dm ^ pol, "R7", tag);
        chk(b_vid, e_vid,      "R9", tag);
    endtask

    task automatic step(input logic ls, input logic p, input logic r, input string tag);
        @(negedge clk);
        rst = r;
        line_start = ls;
        clamp_active_low = p;
        #1;
        if (!r) compare(tag);
        @(posedge clk);
        pos_a = (r || ls) ? 0 : ((pos_a == LA - 1) ? 0 : pos_a + 1);
        pos_b = (r || ls) ? 0 : ((pos_b == LB - 1) ? 0 : pos_b + 1);
    endtask

    task automatic t_reset();
        for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 1'b1, "R1 reset");
        step(1'b0, 1'b0, 1'b0, "R1 after reset");
        chk(pos_a == 1, 1'b1, "R1", "model");
    endtask

    task automatic t_free_run();
        for (int i = 0; i < 2 * LA + 7; i++) step(1'b0, 1'b0, 1'b0, "R2 free run");
    endtask

    task automatic t_restart_mid();
        for (int i = 0; i < 500; i++) step(1'b0, 1'b0, 1'b0, "R2 to mid");
        step(1'b1, 1'b0, 1'b0, "R3 strobe mid");
        for (int i = 0; i < 60; i++) step(1'b0, 1'b0, 1'b0, "R3 after strobe");
    endtask

    task automatic t_restart_in_dummy();
        while (pos_a != LA - 10) step(1'b0, 1'b0, 1'b0, "R5 approach");
        step(1'b1, 1'b0, 1'b0, "R3 strobe in dummy");
        for (int i = 0; i < 50; i++) step(1'b0, 1'b0, 1'b0, "R3 after dummy strobe");
    endtask

    task automatic t_repeat_strobe();
        for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 1'b0, "R3 repeated strobe");
        for (int i = 0; i < 45; i++) step(1'b0, 1'b0, 1'b0, "R3 after repeats");
    endtask

    task automatic t_polarity();
        for (int i = 0; i < LA + 3; i++) step(1'b0, 1'b1, 1'b0, "R8 active low");
        for (int i = 0; i < 20; i++) step(1'b0, 1'b0, 1'b0, "R8 back high");
    endtask

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        t_reset();
        t_free_run();
        t_restart_mid();
        t_restart_in_dummy();
        t_repeat_strobe();
        t_polarity();
        done = 1'b1;
        report();
    end

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000 && !done) begin
                failures++;
                $display("FAIL watchdog actual=%0d expected<150000", cycles);
                report();
            end
        end
    end

endmodule